// File: doc/BRIEF.md
# CPU Exception Priority Sequencer

This block decides which exception a small CPU enters next. It watches a reset input, a watchdog overflow pulse, a trace flag, a pending-interrupt line, a trap-instruction strobe, and an instruction-completion strobe that carries a class code. It issues one registered start pulse for the winning exception type, together with a two-bit type code. The fixed priority is reset first, then trace, then interrupt, then trap.

Reset starts on the clock edge that detects it and does not wait for anything. Trace and interrupt are captured only at acceptance points, which are marked by the completion strobe. The class code of the completed instruction can suppress one of them: a return from exception suppresses trace, and a control-register write or the end of reset handling suppresses interrupt. A trap is captured whenever its strobe arrives and the reset input is low.

Requests that lose the priority choice stay latched. A busy flag blocks further non-reset starts until the CPU acknowledges that it has entered handling.

Top module: `exc_seq`

## Requirements
- R1: `start_o` has at most one bit set. Bit 0 is reset, bit 1 trace, bit 2 interrupt and bit 3 trap. In the same cycle `kind_o` gives the code of that bit: 0 reset, 1 trace, 2 interrupt, 3 trap. Each start lasts exactly one cycle. After system reset `start_o` is 0, `kind_o` is 0 and `busy_o` is 0.
- R2: A rising edge on `rst_pin` drives `start_o` to 4'b0001 after the clock edge that samples it high. This holds even while busy and even when other requests are pending.
- R3: A `wdt_ovf` pulse drives `start_o` to 4'b0001 after the edge that samples it. This also holds even while busy.
- R4: A reset exception (R2 or R3) discards every latched trace, interrupt and trap request, as well as any such request that arrives in the same cycle.
- R5: When several requests are latched, only the highest one starts (trace, then interrupt, then trap). The others stay latched and start later, in that order.
- R6: A start sets `busy_o`. While `busy_o` is high and `ack` is low, no trace, interrupt or trap start occurs. The edge that samples `ack` clears `busy_o`, and a latched request then starts on the next edge.
- R7: On an edge where `done` is high, trace and interrupt requests are latched, unless R8, R9 or R10 suppress them. The start appears two edges after `done` is sampled. The interrupt request stays latched even if `irq_pend` drops afterwards. Class codes 0 and 4 to 7 are treated as normal completions.
- R8: Trace is latched only when `trace_en` is 1 and `ctl_mode` equals 2. In any other mode the trace flag has no effect.
- R9: Trace is not latched when `done_cls` is 1, the return-from-exception class.
- R10: Interrupt is not latched when `done_cls` is 2 (control-register modify) or 3 (end of reset handling).
- R11: A `trap_req` pulse is latched on any edge where `rst_pin` is low, busy or not, and starts two edges later when nothing is in the way. A pulse that arrives while `rst_pin` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous system reset, active low |
| rst_pin | input | 1 | CPU reset input; a rising edge starts reset handling |
| wdt_ovf | input | 1 | Watchdog overflow pulse |
| trace_en | input | 1 | Trace flag from the status register |
| irq_pend | input | 1 | An interrupt request is pending |
| trap_req | input | 1 | Trap instruction executed (one-cycle strobe) |
| done | input | 1 | Instruction or exception handling completed (acceptance point) |
| done_cls | input | CLS_W | Class of the completed item: 0 normal, 1 return from exception, 2 control-register modify, 3 end of reset handling |
| ctl_mode | input | 2 | Interrupt control mode |
| ack | input | 1 | CPU has entered handling; clears busy |
| start_o | output | 4 | One-hot exception start pulse |
| kind_o | output | 2 | Encoded type of the current start |
| busy_o | output | 1 | A start has been issued and not yet acknowledged |

## Verification
The bench builds the block with its default parameters: a 3-bit class field and trace mode 2. The 3-bit class field leaves codes 4 to 7 free, so the bench can confirm that an unlisted class behaves like a normal completion. With trace mode 2, the bench can show trace being taken in mode 2 and ignored in modes 0, 1 and 3. The bench replays simultaneous requests against a small priority model, holds a request back behind the busy flag, and lets a reset arrive over latched requests to show that they are discarded.

// File: rtl/exc_seq.sv
module exc_seq #(
  parameter int         CLS_W      = 3,
  parameter logic [1:0] TRACE_MODE = 2'd2,
  parameter int         CLS_RTE    = 1,
  parameter int         CLS_CTL    = 2,
  parameter int         CLS_RSTEND = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rst_pin,
  input  logic             wdt_ovf,
  input  logic             trace_en,
  input  logic             irq_pend,
  input  logic             trap_req,
  input  logic             done,
  input  logic [CLS_W-1:0] done_cls,
  input  logic [1:0]       ctl_mode,
  input  logic             ack,
  output logic [3:0]       start_o,
  output logic [1:0]       kind_o,
  output logic             busy_o
);
  localparam logic [CLS_W-1:0] C_RTE = CLS_W'(CLS_RTE);
  localparam logic [CLS_W-1:0] C_CTL = CLS_W'(CLS_CTL);
  localparam logic [CLS_W-1:0] C_RND = CLS_W'(CLS_RSTEND);

  logic rst_q, tr_p, ir_p, tp_p;
  logic [3:0] pick;
  logic [1:0] pick_k;

  wire rst_evt = (rst_pin & ~rst_q) | wdt_ovf;
  wire tr_new  = done & trace_en & (ctl_mode == TRACE_MODE) & (done_cls != C_RTE);
  wire ir_new  = done & irq_pend & (done_cls != C_CTL) & (done_cls != C_RND);
  wire tp_new  = trap_req & ~rst_pin;

  always_comb begin
    pick   = 4'b0000;
    pick_k = 2'd0;
    if (!busy_o) begin
      if (tr_p) begin
        pick = 4'b0010; pick_k = 2'd1;
      end else if (ir_p) begin
        pick = 4'b0100; pick_k = 2'd2;
      end else if (tp_p) begin
        pick = 4'b1000; pick_k = 2'd3;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_q   <= 1'b0;
      tr_p    <= 1'b0;
      ir_p    <= 1'b0;
      tp_p    <= 1'b0;
      busy_o  <= 1'b0;
      start_o <= 4'b0000;
      kind_o  <= 2'd0;
    end else begin
      rst_q <= rst_pin;
      if (rst_evt) begin
        start_o <= 4'b0001;
        kind_o  <= 2'd0;
        busy_o  <= 1'b1;
        tr_p    <= 1'b0;
        ir_p    <= 1'b0;
        tp_p    <= 1'b0;
      end else begin
        start_o <= pick;
        if (pick != 4'b0000) kind_o <= pick_k;
        if (pick != 4'b0000) busy_o <= 1'b1;
        else if (ack)        busy_o <= 1'b0;
        tr_p <= (tr_p & ~pick[1]) | tr_new;
        ir_p <= (ir_p & ~pick[2]) | ir_new;
        tp_p <= (tp_p & ~pick[3]) | tp_new;
      end
    end
  end
endmodule

// File: rtl/exc_seq_chk.sv
module exc_seq_chk #(
  parameter int CLS_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rst_pin,
  input logic             wdt_ovf,
  input logic             trace_en,
  input logic             irq_pend,
  input logic             trap_req,
  input logic             done,
  input logic [CLS_W-1:0] done_cls,
  input logic [1:0]       ctl_mode,
  input logic             ack,
  input logic [3:0]       start_o,
  input logic [1:0]       kind_o,
  input logic             busy_o
);
  a_r1_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(start_o));

  a_r1_kind_match: assert property (@(posedge clk) disable iff (!rst_n)
    (start_o != 4'b0000) |-> start_o[kind_o]);

  a_r2_pin_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_pin) |=> (start_o == 4'b0001));

  a_r3_watchdog: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_ovf |=> (start_o == 4'b0001));

  a_r6_busy_on_start: assert property (@(posedge clk) disable iff (!rst_n)
    (start_o != 4'b0000) |-> busy_o);

  a_r6_hold_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !ack && !wdt_ovf && !$rose(rst_pin)) |=> (start_o == 4'b0000));
endmodule

bind exc_seq exc_seq_chk #(.CLS_W(CLS_W)) u_chk (.*);

// File: tb/exc_seq_bench.sv
module exc_seq_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic rst_pin = 0, wdt_ovf = 0, trace_en = 0, irq_pend = 0, trap_req = 0, done = 0, ack = 0;
  logic [2:0] done_cls = 3'd0;
  logic [1:0] ctl_mode = 2'd0;
  logic [3:0] start_o;
  logic [1:0] kind_o;
  logic       busy_o;
  int checks = 0, failures = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  exc_seq u_exc_seq (.*);

  task automatic step(); @(negedge clk); endtask

  task automatic chk(string req, logic [3:0] es, logic [1:0] ek, logic eb);
    checks++;
    if (start_o !== es || busy_o !== eb || (es != 0 && kind_o !== ek)) begin
      failures++;
      $display("FAIL %s: start=%b kind=%0d busy=%b expected start=%b kind=%0d busy=%b",
               req, start_o, kind_o, busy_o, es, ek, eb);
    end
  endtask

  task automatic do_ack(); ack = 1; step(); ack = 0; endtask

  task automatic fire_done(logic [2:0] c);
    done = 1; done_cls = c; step(); done = 0; done_cls = 0;
  endtask

  function automatic logic [3:0] ref_pick(bit tr, bit ir, bit tp);
    if (tr) return 4'b0010;
    if (ir) return 4'b0100;
    if (tp) return 4'b1000;
    return 4'b0000;
  endfunction

  function automatic logic [1:0] enc(logic [3:0] s);
    return s[1] ? 2'd1 : s[2] ? 2'd2 : s[3] ? 2'd3 : 2'd0;
  endfunction

  task automatic t_reset_state();
    chk("R1 idle after reset", 4'b0000, 0, 0);
    checks++;
    if (kind_o !== 2'd0) begin
      failures++; $display("FAIL R1 kind after reset: %0d expected 0", kind_o);
    end
  endtask

  task automatic t_pin();
    rst_pin = 1; step();
    chk("R2 pin rise", 4'b0001, 0, 1);
    step();
    chk("R1 single pulse", 4'b0000, 0, 1);
    rst_pin = 0; do_ack();
    chk("R6 ack clears busy", 4'b0000, 0, 0);
  endtask

  task automatic t_wdt();
    trap_req = 1; step(); trap_req = 0; step();
    chk("R11 trap start", 4'b1000, 3, 1);
    wdt_ovf = 1; step(); wdt_ovf = 0;
    chk("R3 watchdog while busy", 4'b0001, 0, 1);
    do_ack();
  endtask

  task automatic t_simul();
    bit tr = 1, ir = 1, tp = 1;
    ctl_mode = 2; trace_en = 1; irq_pend = 1; trap_req = 1;
    fire_done(3'd0);
    trap_req = 0; trace_en = 0; irq_pend = 0;
    for (int i = 0; i < 3; i++) begin
      logic [3:0] e;
      e = ref_pick(tr, ir, tp);
      step();
      chk("R5 priority order", e, enc(e), 1);
      if (i == 0) begin
        step(); chk("R6 held while busy", 4'b0000, 0, 1);
      end
      tr = tr & ~e[1]; ir = ir & ~e[2]; tp = tp & ~e[3];
      do_ack();
    end
    step();
    chk("R5 nothing left", 4'b0000, 0, 0);
  endtask

  task automatic t_mode();
    trace_en = 1;
    for (int m = 0; m < 4; m++) begin
      if (m == 2) continue;
      ctl_mode = 2'(m);
      fire_done(3'd0); step();
      chk("R8 trace ignored outside mode 2", 4'b0000, 0, 0);
    end
    ctl_mode = 2;
    fire_done(3'd0); step();
    chk("R8 trace in mode 2", 4'b0010, 1, 1);
    do_ack(); trace_en = 0;
  endtask

  task automatic t_rte();
    ctl_mode = 2; trace_en = 1; irq_pend = 1;
    fire_done(3'd1);
    trace_en = 0; irq_pend = 0; step();
    chk("R9 trace suppressed after return", 4'b0100, 2, 1);
    do_ack(); step();
    chk("R9 no trace left", 4'b0000, 0, 0);
  endtask

  task automatic t_ctl();
    ctl_mode = 2; trace_en = 1; irq_pend = 1;
    fire_done(3'd2);
    trace_en = 0; irq_pend = 0; step();
    chk("R10 ctl modify: trace only", 4'b0010, 1, 1);
    do_ack(); step();
    chk("R10 ctl modify: no interrupt", 4'b0000, 0, 0);
    irq_pend = 1; fire_done(3'd3); irq_pend = 0; step();
    chk("R10 end of reset: no interrupt", 4'b0000, 0, 0);
    irq_pend = 1; fire_done(3'd5); irq_pend = 0; step();
    chk("R7 unlisted class is normal", 4'b0100, 2, 1);
    do_ack();
  endtask

  task automatic t_clear();
    trap_req = 1; step(); trap_req = 0; step();
    chk("R11 trap start", 4'b1000, 3, 1);
    ctl_mode = 2; trace_en = 1; irq_pend = 1; trap_req = 1;
    fire_done(3'd0);
    trace_en = 0; irq_pend = 0; trap_req = 0;
    rst_pin = 1; step();
    chk("R4 reset over pending", 4'b0001, 0, 1);
    do_ack(); step();
    chk("R4 pending discarded", 4'b0000, 0, 0);
    step();
    chk("R4 still quiet", 4'b0000, 0, 0);
  endtask

  task automatic t_trap_in_reset();
    trap_req = 1; step(); trap_req = 0; step();
    chk("R11 trap ignored with reset high", 4'b0000, 0, 0);
    rst_pin = 0; step();
    trap_req = 1; step(); trap_req = 0; step();
    chk("R11 trap after reset low", 4'b1000, 3, 1);
    do_ack();
  endtask

  initial begin
    repeat (3) step();
    rst_n = 1; step();
    t_reset_state();
    t_pin();
    t_wdt();
    t_simul();
    t_mode();
    t_rte();
    t_ctl();
    t_clear();
    t_trap_in_reset();
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++; failures++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule